// File: doc/BRIEF.md
# Lane Partition Extent Decoder

A word is built from equal 8-bit lanes. Between each pair of neighbouring lanes sits one gate bit; a 1 there marks a partition boundary. The block treats the two word edges as boundaries that are always set. With those two guard boundaries added, any stretch of lanes that has a set boundary at each end and only clear boundaries inside it is one complete partition.

A caller picks a starting lane. The block reports whether a whole partition begins at that lane and how many lanes it covers. It also gives a one-hot code naming the (length, offset) pair that matched, and the partition's bytes moved down to bit 0 with every bit above the partition cleared. The block is purely combinational and has no clock or reset. It is meant to sit inside lane-parallel datapaths that need to isolate one sub-word. The lane count is a parameter: the default is 4 lanes, and 8 lanes is also expected.

Top module: `lane_part_decoder`

## Requirements
- R1: Boundary b[0] below lane 0 and boundary b[LANES] above the top lane are always 1. Boundary b[i] for 1 <= i < LANES equals gate_i[i-1], which is the boundary between lane i-1 and lane i.
- R2: With boundaries b[o] and b[o+1] both set, start_i = o gives valid_o = 1 and len_o = 1.
- R3: With b[start_i] = 1, len_o is the distance from start_i up to the next set boundary above it (the top guard included), so b[start_i+len_o] = 1.
- R4: With all gate bits 0 and start_i = 0, valid_o = 1 and len_o = LANES.
- R5: With b[start_i] = 0, valid_o, len_o, hit_o and data_o are all 0.
- R6: On a valid result, data_o[8*k +: 8] equals data_i[8*(start_i+k) +: 8] for every k < len_o.
- R7: On a valid result, every data_o bit at position 8*len_o or higher is 0.
- R8: hit_o has one bit for each legal (length L, offset o) pair with o <= LANES-L. The bits are ordered by length first and then by offset, so pair (L, o) is bit sum over k<L of (LANES-k+1), plus o. For example, with 4 lanes (1,0) is bit 0, (2,0) is bit 4, (3,0) is bit 7 and (4,0) is bit 9. When valid_o is 1, exactly the bit for (len_o, start_i) is set; otherwise no bit is set.
- R9: Every output settles from the present inputs alone, with no clock edge needed between an input change and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gate_i | input | LANES-1 | Internal boundary bits; bit i sits between lane i and lane i+1 |
| start_i | input | $clog2(LANES) | Lane at which the partition is tested |
| data_i | input | 8*LANES | Full data word |
| valid_o | output | 1 | A complete partition begins at start_i |
| len_o | output | $clog2(LANES+1) | Partition length in lanes, 0 when not valid |
| hit_o | output | LANES*(LANES+1)/2 | One-hot (length, offset) code |
| data_o | output | 8*LANES | Partition data moved down to bit 0, upper bits cleared |

## Verification
The embedded checks assume that start_i always names an existing lane, which holds for any value when LANES is a power of two. The bench therefore only runs power-of-two lane counts. The checks also rely on the guard convention: at the top of the word the closing boundary is implied rather than taken from an input. The bench builds its boundary vector under that same rule and then sweeps every gate pattern against every start lane. Every bench vector is therefore legal by construction.

// File: rtl/lane_part_pkg.sv
package lane_part_pkg;
  localparam int unsigned LANE_W = 8;

  // first hit bit for partitions of length len
  function automatic int unsigned pair_base(int unsigned lanes, int unsigned len);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 1; k < len; k++) acc += lanes - k + 1;
    return acc;
  endfunction

  function automatic int unsigned pair_count(int unsigned lanes);
    return lanes * (lanes + 1) / 2;
  endfunction
endpackage

// File: rtl/lane_part_bounds.sv
module lane_part_bounds #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-2:0] gate_i,
  output logic [LANES:0]   bnd_o
);
  // guard boundaries at both word edges
  assign bnd_o = {1'b1, gate_i, 1'b1};
endmodule

// File: rtl/lane_part_match.sv
module lane_part_match
  import lane_part_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned SW    = $clog2(LANES),
  localparam int unsigned PAIRS = pair_count(LANES)
) (
  input  logic [LANES:0]   bnd_i,
  input  logic [SW-1:0]    start_i,
  output logic [PAIRS-1:0] sel_o
);
  function automatic logic [LANES:0] inner_mask(int unsigned off, int unsigned len);
    logic [LANES:0] m;
    m = '0;
    for (int unsigned i = 1; i < len; i++) m[off+i] = 1'b1;
    return m;
  endfunction

  for (genvar gl = 1; gl <= LANES; gl++) begin : g_len
    for (genvar go = 0; go <= LANES - gl; go++) begin : g_off
      localparam int unsigned IDX = pair_base(LANES, gl) + go;
      localparam logic [LANES:0] INNER = inner_mask(go, gl);
      assign sel_o[IDX] = bnd_i[go] & bnd_i[go+gl] & ~|(bnd_i & INNER)
                        & (start_i == SW'(go));
    end
  end
endmodule

// File: rtl/lane_part_extent.sv
module lane_part_extent
  import lane_part_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned LW    = $clog2(LANES + 1),
  localparam int unsigned PAIRS = pair_count(LANES)
) (
  input  logic [PAIRS-1:0] sel_i,
  output logic             valid_o,
  output logic [LW-1:0]    len_o
);
  always_comb begin
    len_o = '0;
    for (int unsigned l = 1; l <= LANES; l++)
      for (int unsigned o = 0; o <= LANES - l; o++)
        if (sel_i[pair_base(LANES, l) + o]) len_o = len_o | LW'(l);
    valid_o = |sel_i;
  end
endmodule

// File: rtl/lane_part_align.sv
module lane_part_align
  import lane_part_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned SW = $clog2(LANES),
  localparam int unsigned LW = $clog2(LANES + 1),
  localparam int unsigned W  = LANES * LANE_W
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] start_i,
  input  logic [LW-1:0] len_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] shifted;
  logic [W-1:0] keep;

  always_comb begin
    shifted = data_i >> (32'(start_i) * LANE_W);
    keep = '0;
    for (int unsigned l = 1; l <= LANES; l++)
      if (len_i == LW'(l)) keep = {W{1'b1}} >> (W - l * LANE_W);
    data_o = shifted & keep;
  end
endmodule

// File: rtl/lane_part_decoder.sv
module lane_part_decoder
  import lane_part_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned SW    = $clog2(LANES),
  localparam int unsigned LW    = $clog2(LANES + 1),
  localparam int unsigned W     = LANES * LANE_W,
  localparam int unsigned PAIRS = pair_count(LANES)
) (
  input  logic [LANES-2:0] gate_i,
  input  logic [SW-1:0]    start_i,
  input  logic [W-1:0]     data_i,
  output logic             valid_o,
  output logic [LW-1:0]    len_o,
  output logic [PAIRS-1:0] hit_o,
  output logic [W-1:0]     data_o
);
  logic [LANES:0] bnd;

  lane_part_bounds #(.LANES(LANES)) u_bounds (.gate_i(gate_i), .bnd_o(bnd));

  lane_part_match #(.LANES(LANES)) u_match (
    .bnd_i(bnd), .start_i(start_i), .sel_o(hit_o)
  );

  lane_part_extent #(.LANES(LANES)) u_extent (
    .sel_i(hit_o), .valid_o(valid_o), .len_o(len_o)
  );

  lane_part_align #(.LANES(LANES)) u_align (
    .data_i(data_i), .start_i(start_i), .len_i(len_o), .data_o(data_o)
  );

  always_comb begin
    // R5
    idle_chk: assert (valid_o || (len_o == '0 && data_o == '0 && hit_o == '0));
    // R8
    onehot_chk: assert ($onehot0(hit_o));
    // R1
    start_chk: assert (valid_o == bnd[start_i]);
    // R3
    span_chk: assert (!valid_o || (32'(start_i) + 32'(len_o) <= LANES
                      && bnd[32'(start_i) + 32'(len_o)]));
    // R7
    upper_chk: assert (!valid_o || ((data_o >> (32'(len_o) * LANE_W)) == '0));
  end
endmodule

// File: tb/lane_part_decoder_test.sv
module lane_part_decoder_test;
  localparam int unsigned LANES = 4;
  localparam int unsigned SW    = $clog2(LANES);
  localparam int unsigned LW    = $clog2(LANES + 1);
  localparam int unsigned W     = LANES * 8;
  localparam int unsigned PAIRS = LANES * (LANES + 1) / 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [LANES-2:0] gate;
  logic [SW-1:0]    start;
  logic [W-1:0]     data;
  logic             valid;
  logic [LW-1:0]    len;
  logic [PAIRS-1:0] hit;
  logic [W-1:0]     dout;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  lane_part_decoder #(.LANES(LANES)) uut (
    .gate_i(gate), .start_i(start), .data_i(data),
    .valid_o(valid), .len_o(len), .hit_o(hit), .data_o(dout)
  );

  function automatic int unsigned base_of(int unsigned l);
    int unsigned acc = 0;
    for (int unsigned k = 1; k < l; k++) acc += LANES - k + 1;
    return acc;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [LANES-2:0] g, logic [SW-1:0] s, logic [W-1:0] d);
    @(posedge clk);
    #1;
    gate = g; start = s; data = d;
    #1;
  endtask

  // full reference check against the requirement model
  task automatic check_model(string req);
    logic [LANES:0] b;
    int unsigned l;
    logic [63:0] e_data;
    logic [63:0] e_hit;
    b = {1'b1, gate, 1'b1};
    l = 0;
    e_data = 0;
    e_hit = 0;
    if (b[start]) begin
      l = 1;
      while (!b[int'(start) + l]) l++;
      for (int unsigned k = 0; k < l; k++)
        e_data[8*k +: 8] = data[8*(int'(start)+k) +: 8];
      e_hit = 64'd1 << (base_of(l) + start);
    end
    chk({req, " valid"}, 64'(valid), 64'(b[start]));
    chk({req, " len"}, 64'(len), 64'(l));
    chk({req, " hit"}, 64'(hit), e_hit);
    chk({req, " data"}, 64'(dout), e_data);
  endtask

  task automatic t_reset_state;
    apply('0, '0, '0);
    chk("R4 idle-input len", 64'(len), 64'(LANES));
    chk("R4 idle-input valid", 64'(valid), 64'd1);
  endtask

  task automatic t_single_lane;
    apply(3'b111, 2'd2, 32'hDDCCBBAA);
    chk("R2 len", 64'(len), 64'd1);
    chk("R6 data", 64'(dout), 64'h0000_00CC);
    chk("R8 hit bit2", 64'(hit), 64'd1 << 2);
  endtask

  task automatic t_two_lane;
    apply(3'b101, 2'd1, 32'hDDCCBBAA);
    chk("R3 len", 64'(len), 64'd2);
    chk("R6 data", 64'(dout), 64'h0000_CCBB);
    chk("R8 hit bit5", 64'(hit), 64'd1 << 5);
  endtask

  task automatic t_top_guard;
    apply(3'b001, 2'd1, 32'h44332211);
    chk("R1 top guard len", 64'(len), 64'd3);
    chk("R7 upper clear", 64'(dout), 64'h0044_3322);
    chk("R8 hit bit8", 64'(hit), 64'd1 << 8);
  endtask

  task automatic t_full;
    apply(3'b000, 2'd0, 32'hCAFEF00D);
    chk("R4 len", 64'(len), 64'(LANES));
    chk("R6 data", 64'(dout), 64'hCAFEF00D);
    chk("R8 hit bit9", 64'(hit), 64'd1 << 9);
  endtask

  task automatic t_not_start;
    apply(3'b000, 2'd2, 32'hFFFFFFFF);
    chk("R5 valid", 64'(valid), 64'd0);
    chk("R5 len", 64'(len), 64'd0);
    chk("R5 hit", 64'(hit), 64'd0);
    chk("R5 data", 64'(dout), 64'd0);
  endtask

  task automatic t_comb;
    apply(3'b010, 2'd0, 32'h12345678);
    // no clock edge between these input changes and samples
    gate = 3'b011; #0.5;
    chk("R9 len", 64'(len), 64'd1);
    start = 2'd1; #0.5;
    chk("R9 len", 64'(len), 64'd1);
    chk("R9 data", 64'(dout), 64'h56);
  endtask

  task automatic t_sweep;
    for (int g = 0; g < (1 << (LANES - 1)); g++)
      for (int s = 0; s < LANES; s++) begin
        apply((LANES-1)'(g), SW'(s), 32'hA1B2C3D4 ^ 32'(g * 32'h01010101));
        check_model("R8 sweep");
      end
  endtask

  initial begin
    gate = '0; start = '0; data = '0;
    t_reset_state();
    t_single_lane();
    t_two_lane();
    t_top_guard();
    t_full();
    t_not_start();
    t_comb();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule